// File: doc/BRIEF.md
# Table-Driven Raster Timing Sequencer

This block produces the sync pulses, visible-area qualifiers and pixel coordinates of a 640x480 raster at a 25 MHz dot clock. It also marks a 512x256 window placed inside the visible area. Each axis is a small step machine that walks a six-entry segment list. An entry holds six control bits and a terminal count. A per-axis counter runs until it matches that count, then it clears and the machine moves to the next entry. The horizontal machine advances every clock. The vertical machine advances once at the end of each line.

The two margins that surround the window on each axis take their length from a pair of opposing offset registers instead of from the list. A 2-bit command per axis moves the window one step forward or back, or returns it to the centre. Commands are caught on their leading edge and held. They are applied only while both axes are in their sync segment, so a visible frame never changes shape while it is being drawn. The timing segment lengths are parameters. The defaults give an 800-clock line and a 525-line frame.

Top module: `raster_timer`

## Requirements
- R1: A line lasts H_SYNC+H_BACK+2*H_MARGIN+H_WIN+H_FRONT clocks (800 by default). The first line starts at the first clock after reset is released. `hsync_n` is low for the first H_SYNC clocks of every line and high for the rest.
- R2: `scr_h_valid` is high for 2*H_MARGIN+H_WIN clocks (640), starting H_SYNC+H_BACK clocks (144) after the line starts. While it is high, `scr_x` counts 0, 1, 2 and so on. At all other times `scr_x` is 0.
- R3: `win_h_valid` is high for H_WIN clocks, starting H_SYNC+H_BACK+L+1 clocks after the line starts. L is the horizontal leading offset, which resets to H_MARGIN-1 (63). While the window is marked, `win_x` counts 0 to H_WIN-1. At all other times it is 0.
- R4: A frame lasts V_SYNC+V_BACK+2*V_MARGIN+V_WIN+V_FRONT lines (525). Vertical state changes only at line ends. `vsync_n` is low for the first V_SYNC lines of the frame.
- R5: `scr_v_valid` is high for 2*V_MARGIN+V_WIN lines (480), starting at line V_SYNC+V_BACK of the frame. While it is high, `scr_y` holds the active-line number. At all other times it is 0.
- R6: `win_v_valid` is high for V_WIN lines, starting at line V_SYNC+V_BACK+T+1. T is the vertical leading offset, which resets to V_MARGIN-1 (111). While the window is marked, `win_y` holds the window row. At all other times it is 0.
- R7: Each axis keeps a leading offset and a trailing offset. Both reset to MARGIN-1, and their sum never changes. The command field is `shift_cmd[1:0]` for the horizontal axis and `shift_cmd[3:2]` for the vertical axis. Code 01 raises the leading offset by one and lowers the trailing offset by one, so the window moves later. Code 10 does the reverse. Code 11 reloads both offsets to MARGIN-1. Code 00 does nothing.
- R8: A command is registered once, when its field changes from 00 to a nonzero value. Holding the field, or changing it from one nonzero code to another, registers nothing new. A newer registered command replaces one that has not yet been applied.
- R9: A registered command is applied on the first clock at which both axes are in their sync segment, that is, within the first H_SYNC clocks of one of the first V_SYNC lines. Line length and frame length never change.
- R10: A forward step is ignored when the trailing offset is 0. A backward step is ignored when the leading offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_cmd | input | 4 | Window move commands: [1:0] horizontal, [3:2] vertical |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| scr_h_valid | output | 1 | Inside the visible columns |
| scr_v_valid | output | 1 | Inside the visible lines |
| scr_x | output | SX_W (10) | Visible column, 0 outside |
| scr_y | output | SY_W (10) | Visible line, 0 outside |
| win_h_valid | output | 1 | Inside the window columns |
| win_v_valid | output | 1 | Inside the window lines |
| win_x | output | WX_W (9) | Window column, 0 outside |
| win_y | output | WY_W (8) | Window row, 0 outside |

## Verification
A wrong segment index or count inside a line shows up at the ports within that same line. It moves a sync or qualifier edge, breaks a coordinate ramp, or changes the 800-clock period. A vertical fault shows up by the next line end. A corrupted offset register stays hidden until the margin segment that reads it. It then shifts the window edges on the very next line, and also the trailing edge if the pair's sum drifts. Because commands are deferred, an edge-detect or deferral fault appears as a window that moves one frame early, one frame late, twice, or not at all. Comparing the outputs against a reference model on every clock catches each of these cases.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // width of a segment terminal count and of the offset registers
    localparam int CNT_W = 10;
    // segments per axis: sync, back porch, lead margin, window, trail margin, front porch
    localparam int SEG_N = 6;
    localparam int IDX_W = $clog2(SEG_N);

    typedef struct packed {
        logic sync_lvl;  // level driven on the sync output
        logic act;       // visible-area qualifier
        logic win;       // window qualifier
        logic use_off;   // duration comes from an offset register
        logic off_neg;   // pick the trailing register instead of the leading one
        logic last;      // return to entry 0 after this segment
    } seg_ctrl_t;

    typedef struct packed {
        seg_ctrl_t        ctrl;
        logic [CNT_W-1:0] term;
    } seg_entry_t;

    typedef seg_entry_t [SEG_N-1:0] seg_table_t;

    typedef enum logic [1:0] {
        SHIFT_HOLD   = 2'b00,
        SHIFT_FWD    = 2'b01,
        SHIFT_BACK   = 2'b10,
        SHIFT_CENTER = 2'b11
    } shift_cmd_e;

    function automatic seg_entry_t mk_seg(input logic sync_lvl, input logic act,
                                          input logic win, input logic use_off,
                                          input logic off_neg, input logic last,
                                          input int len);
        seg_entry_t e;
        e.ctrl.sync_lvl = sync_lvl;
        e.ctrl.act      = act;
        e.ctrl.win      = win;
        e.ctrl.use_off  = use_off;
        e.ctrl.off_neg  = off_neg;
        e.ctrl.last     = last;
        e.term          = CNT_W'(len - 1);
        return e;
    endfunction

    // segment lengths in clocks (or lines); the table stores length-1
    function automatic seg_table_t build_table(input int sync_len, input int back_len,
                                               input int marg_len, input int win_len,
                                               input int front_len);
        seg_table_t t;
        t[0] = mk_seg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, sync_len);
        t[1] = mk_seg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, back_len);
        t[2] = mk_seg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, marg_len);
        t[3] = mk_seg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, win_len);
        t[4] = mk_seg(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, marg_len);
        t[5] = mk_seg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, front_len);
        return t;
    endfunction

endpackage

// File: rtl/offset_pair.sv
module offset_pair
    import raster_pkg::*;
#(
    parameter int INIT = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd,
    input  logic             apply,
    output logic [CNT_W-1:0] lead_term,
    output logic [CNT_W-1:0] trail_term
);
    localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT);
    localparam logic [CNT_W:0]   SUM_V  = (CNT_W+1)'(2 * INIT);

    typedef struct packed {
        logic [1:0]       prev;
        logic [1:0]       pend;
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] trail;
    } off_state_t;

    off_state_t st_q, st_d;
    logic       req;

    always_comb begin
        st_d      = st_q;
        req       = (cmd != 2'b00) && (st_q.prev == 2'b00);
        st_d.prev = cmd;
        if (apply) begin
            case (shift_cmd_e'(st_q.pend))
                SHIFT_FWD: begin
                    if (st_q.trail != '0) begin
                        st_d.lead  = st_q.lead + 1'b1;
                        st_d.trail = st_q.trail - 1'b1;
                    end
                end
                SHIFT_BACK: begin
                    if (st_q.lead != '0) begin
                        st_d.lead  = st_q.lead - 1'b1;
                        st_d.trail = st_q.trail + 1'b1;
                    end
                end
                SHIFT_CENTER: begin
                    st_d.lead  = INIT_V;
                    st_d.trail = INIT_V;
                end
                default: ;
            endcase
            st_d.pend = req ? cmd : 2'b00;
        end else if (req) begin
            st_d.pend = cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{prev: 2'b00, pend: 2'b00, lead: INIT_V, trail: INIT_V};
        end else begin
            st_q <= st_d;
        end
    end

    assign lead_term  = st_q.lead;
    assign trail_term = st_q.trail;

    // R7: the pair keeps a constant sum, so line/frame length is preserved
    a_r7_sum_const: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.lead} + {1'b0, st_q.trail}) == SUM_V);

    // R9: offsets move only on a cycle where the apply window is open
    a_r9_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(st_q.lead));

    // R10: clamping keeps the leading offset inside 0..sum
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.lead} <= SUM_V);

endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
    import raster_pkg::*;
#(
    parameter int SYNC_LEN  = 96,
    parameter int BACK_LEN  = 48,
    parameter int MARG_LEN  = 64,
    parameter int WIN_LEN   = 512,
    parameter int FRONT_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] lead_term,
    input  logic [CNT_W-1:0] trail_term,
    output seg_ctrl_t        ctrl,
    output logic [IDX_W-1:0] idx,
    output logic             wrap
);
    localparam seg_table_t TABLE = build_table(SYNC_LEN, BACK_LEN, MARG_LEN,
                                               WIN_LEN, FRONT_LEN);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t       st_q, st_d;
    seg_entry_t       cur;
    logic [CNT_W-1:0] limit;
    logic             at_end;

    always_comb begin
        cur    = TABLE[st_q.idx];
        limit  = cur.ctrl.use_off ? (cur.ctrl.off_neg ? trail_term : lead_term)
                                  : cur.term;
        at_end = (st_q.cnt == limit);
        st_d   = st_q;
        if (step) begin
            if (at_end) begin
                st_d.cnt = '0;
                st_d.idx = cur.ctrl.last ? '0 : st_q.idx + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = cur.ctrl;
    assign idx  = st_q.idx;
    assign wrap = step && at_end && cur.ctrl.last;

    // R1 R4: the running count never passes the terminal of its segment
    a_r1_r4_cnt_within: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= limit);

    // R4: the entry index stays inside the table
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.idx) < SEG_N);

    // R4: without a step the position is frozen
    a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(st_q.idx) && $stable(st_q.cnt)));

endmodule

// File: rtl/run_counter.sv
module run_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = en ? cnt_q + {{(W-1){1'b0}}, tick} : '0;
        value = en ? cnt_q : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int H_SYNC   = 96,
    parameter int H_BACK   = 48,
    parameter int H_MARGIN = 64,
    parameter int H_WIN    = 512,
    parameter int H_FRONT  = 16,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33,
    parameter int V_MARGIN = 112,
    parameter int V_WIN    = 256,
    parameter int V_FRONT  = 10,
    parameter int SX_W     = 10,
    parameter int SY_W     = 10,
    parameter int WX_W     = 9,
    parameter int WY_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      shift_cmd,
    output logic            hsync_n,
    output logic            vsync_n,
    output logic            scr_h_valid,
    output logic            scr_v_valid,
    output logic [SX_W-1:0] scr_x,
    output logic [SY_W-1:0] scr_y,
    output logic            win_h_valid,
    output logic            win_v_valid,
    output logic [WX_W-1:0] win_x,
    output logic [WY_W-1:0] win_y
);
    localparam int H_INIT = H_MARGIN - 1;
    localparam int V_INIT = V_MARGIN - 1;

    logic [CNT_W-1:0] h_lead, h_trail, v_lead, v_trail;
    seg_ctrl_t        h_ctrl, v_ctrl;
    logic [IDX_W-1:0] h_idx, v_idx;
    logic             line_end, frame_end;
    logic             apply;

    // both axes in their sync segment: geometry is invisible here
    assign apply = (h_idx == '0) && (v_idx == '0);

    offset_pair #(.INIT(H_INIT)) u_hoff (
        .clk(clk), .rst_n(rst_n), .cmd(shift_cmd[1:0]), .apply(apply),
        .lead_term(h_lead), .trail_term(h_trail)
    );

    offset_pair #(.INIT(V_INIT)) u_voff (
        .clk(clk), .rst_n(rst_n), .cmd(shift_cmd[3:2]), .apply(apply),
        .lead_term(v_lead), .trail_term(v_trail)
    );

    seg_sequencer #(
        .SYNC_LEN(H_SYNC), .BACK_LEN(H_BACK), .MARG_LEN(H_MARGIN),
        .WIN_LEN(H_WIN), .FRONT_LEN(H_FRONT)
    ) u_hseq (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .lead_term(h_lead), .trail_term(h_trail),
        .ctrl(h_ctrl), .idx(h_idx), .wrap(line_end)
    );

    seg_sequencer #(
        .SYNC_LEN(V_SYNC), .BACK_LEN(V_BACK), .MARG_LEN(V_MARGIN),
        .WIN_LEN(V_WIN), .FRONT_LEN(V_FRONT)
    ) u_vseq (
        .clk(clk), .rst_n(rst_n), .step(line_end),
        .lead_term(v_lead), .trail_term(v_trail),
        .ctrl(v_ctrl), .idx(v_idx), .wrap(frame_end)
    );

    assign hsync_n     = h_ctrl.sync_lvl;
    assign vsync_n     = v_ctrl.sync_lvl;
    assign scr_h_valid = h_ctrl.act;
    assign scr_v_valid = v_ctrl.act;
    assign win_h_valid = h_ctrl.win;
    assign win_v_valid = v_ctrl.win;

    run_counter #(.W(SX_W)) u_sx (
        .clk(clk), .rst_n(rst_n), .en(h_ctrl.act), .tick(1'b1), .value(scr_x)
    );

    run_counter #(.W(SY_W)) u_sy (
        .clk(clk), .rst_n(rst_n), .en(v_ctrl.act), .tick(line_end), .value(scr_y)
    );

    run_counter #(.W(WX_W)) u_wx (
        .clk(clk), .rst_n(rst_n), .en(h_ctrl.win), .tick(1'b1), .value(win_x)
    );

    run_counter #(.W(WY_W)) u_wy (
        .clk(clk), .rst_n(rst_n), .en(v_ctrl.win), .tick(line_end), .value(win_y)
    );

    // R4: vertical position moves only at a line end
    a_r4_vstep_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(v_idx));

    // R4: a frame can only close at a line end
    a_r4_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> line_end);

    // R1: sync is never asserted inside visible columns
    a_r1_sync_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !scr_h_valid);

    // R3: window columns lie inside the visible columns
    a_r3_win_in_screen: assert property (@(posedge clk) disable iff (!rst_n)
        win_h_valid |-> scr_h_valid);

    // R6: window lines lie inside the visible lines
    a_r6_win_in_screen: assert property (@(posedge clk) disable iff (!rst_n)
        win_v_valid |-> scr_v_valid);

endmodule

// File: tb/raster_timer_test.sv
module raster_timer_test;

    localparam int HS = 4, HB = 3, HM = 5, HW = 8, HF = 2;
    localparam int VS = 2, VB = 2, VM = 3, VW = 4, VF = 1;
    localparam int LINE  = HS + HB + 2*HM + HW + HF;
    localparam int FRAME = VS + VB + 2*VM + VW + VF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_h = 2'b00;
    logic [1:0] cmd_v = 2'b00;
    logic       hsync_n, vsync_n, scr_h_valid, scr_v_valid, win_h_valid, win_v_valid;
    logic [9:0] scr_x, scr_y;
    logic [8:0] win_x;
    logic [7:0] win_y;

    always #5 clk = ~clk;

    raster_timer #(
        .H_SYNC(HS), .H_BACK(HB), .H_MARGIN(HM), .H_WIN(HW), .H_FRONT(HF),
        .V_SYNC(VS), .V_BACK(VB), .V_MARGIN(VM), .V_WIN(VW), .V_FRONT(VF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .shift_cmd({cmd_v, cmd_h}),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .scr_h_valid(scr_h_valid), .scr_v_valid(scr_v_valid),
        .scr_x(scr_x), .scr_y(scr_y),
        .win_h_valid(win_h_valid), .win_v_valid(win_v_valid),
        .win_x(win_x), .win_y(win_y)
    );

    int    nchk = 0, nbad = 0;
    int    t = 0;
    int    lh = HM - 1, lv = VM - 1;
    int    pend_h = 0, pend_v = 0, prev_h = 0, prev_v = 0;
    string phase = "R1";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
        end
    endtask

    function automatic int step_off(input int l, input int c, input int sum);
        if (c == 1) return ((sum - l) != 0) ? l + 1 : l;
        if (c == 2) return (l != 0) ? l - 1 : l;
        if (c == 3) return sum / 2;
        return l;
    endfunction

    task automatic check_outputs();
        int p, r, hs, wxs, vs, wys;
        bit e_ha, e_wx, e_va, e_wy;
        p   = t % LINE;
        r   = (t / LINE) % FRAME;
        hs  = HS + HB;
        wxs = hs + lh + 1;
        vs  = VS + VB;
        wys = vs + lv + 1;
        e_ha = (p >= hs) && (p < hs + 2*HM + HW);
        e_wx = (p >= wxs) && (p < wxs + HW);
        e_va = (r >= vs) && (r < vs + 2*VM + VW);
        e_wy = (r >= wys) && (r < wys + VW);
        chk(hsync_n == !(p < HS), {"R1 ", phase}, int'(hsync_n), int'(!(p < HS)));
        chk(scr_h_valid == e_ha, {"R2 ", phase}, int'(scr_h_valid), int'(e_ha));
        chk(int'(scr_x) == (e_ha ? p - hs : 0), {"R2 ", phase}, int'(scr_x), e_ha ? p - hs : 0);
        chk(win_h_valid == e_wx, {"R3 ", phase}, int'(win_h_valid), int'(e_wx));
        chk(int'(win_x) == (e_wx ? p - wxs : 0), {"R3 ", phase}, int'(win_x), e_wx ? p - wxs : 0);
        chk(vsync_n == !(r < VS), {"R4 ", phase}, int'(vsync_n), int'(!(r < VS)));
        chk(scr_v_valid == e_va, {"R5 ", phase}, int'(scr_v_valid), int'(e_va));
        chk(int'(scr_y) == (e_va ? r - vs : 0), {"R5 ", phase}, int'(scr_y), e_va ? r - vs : 0);
        chk(win_v_valid == e_wy, {"R6 ", phase}, int'(win_v_valid), int'(e_wy));
        chk(int'(win_y) == (e_wy ? r - wys : 0), {"R6 ", phase}, int'(win_y), e_wy ? r - wys : 0);
    endtask

    // model of the state change at the coming rising edge
    task automatic model_step();
        int  p, r;
        bit  ap, rq_h, rq_v;
        p    = t % LINE;
        r    = (t / LINE) % FRAME;
        ap   = (p < HS) && (r < VS);
        rq_h = (cmd_h != 0) && (prev_h == 0);
        rq_v = (cmd_v != 0) && (prev_v == 0);
        if (ap && pend_h != 0) lh = step_off(lh, pend_h, 2*(HM-1));
        if (ap && pend_v != 0) lv = step_off(lv, pend_v, 2*(VM-1));
        pend_h = rq_h ? int'(cmd_h) : (ap ? 0 : pend_h);
        pend_v = rq_v ? int'(cmd_v) : (ap ? 0 : pend_v);
        prev_h = int'(cmd_h);
        prev_v = int'(cmd_v);
        t++;
    endtask

    // called at a falling edge; leaves at a falling edge
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            check_outputs();
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic to_row(input int rr);
        while (!(((t / LINE) % FRAME) == rr && (t % LINE) == 0)) run(1);
    endtask

    task automatic press(input logic [1:0] h, input logic [1:0] v);
        cmd_h = h;
        cmd_v = v;
        run(3);
        cmd_h = 2'b00;
        cmd_v = 2'b00;
        run(1);
    endtask

    initial begin
        #1_500_000;
        nchk++;
        nbad++;
        $display("FAIL watchdog expired at t=%0d", t);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        // reset state: sync segment of both axes, nothing visible
        chk(hsync_n == 1'b0, "R1 reset", int'(hsync_n), 0);
        chk(vsync_n == 1'b0, "R4 reset", int'(vsync_n), 0);
        chk(scr_h_valid == 1'b0 && scr_x == '0, "R2 reset", int'(scr_x), 0);
        chk(win_h_valid == 1'b0 && win_x == '0, "R3 reset", int'(win_x), 0);
        chk(scr_v_valid == 1'b0 && scr_y == '0, "R5 reset", int'(scr_y), 0);
        chk(win_v_valid == 1'b0 && win_y == '0, "R6 reset", int'(win_y), 0);
        rst_n = 1'b1;

        phase = "R1";
        run(2 * LINE * FRAME);

        // single steps in each direction, then recentre
        phase = "R7";
        to_row(6); press(2'b01, 2'b10);
        to_row(6); press(2'b11, 2'b11);
        to_row(6); press(2'b10, 2'b01);
        to_row(6); press(2'b11, 2'b11);
        to_row(6);

        // edge detection: hold, nonzero-to-nonzero, replacement
        phase = "R8";
        cmd_h = 2'b01; cmd_v = 2'b01; run(40);
        cmd_h = 2'b11; cmd_v = 2'b11; run(10);
        cmd_h = 2'b00; cmd_v = 2'b00; run(1);
        to_row(6);
        press(2'b01, 2'b10); run(5); press(2'b10, 2'b01);
        to_row(6); press(2'b11, 2'b11);
        to_row(6);

        // deferral: command raised inside vertical sync but outside
        // horizontal sync, and one raised just after the last open slot
        phase = "R9";
        to_row(0); run(HS + 1); press(2'b01, 2'b01);
        to_row(6);
        to_row(1); run(HS + 1); press(2'b10, 2'b10);
        to_row(6); to_row(6); press(2'b11, 2'b11);
        to_row(6);

        // clamps: walk past both ends
        phase = "R10";
        for (int k = 0; k < 7; k++) begin
            to_row(8);
            press(2'b10, 2'b01);
        end
        to_row(6);
        for (int k = 0; k < 10; k++) begin
            to_row(8);
            press(2'b01, 2'b10);
        end
        to_row(8); press(2'b11, 2'b11);
        to_row(6);

        // random command traffic
        phase = "R8 R9";
        for (int k = 0; k < 300; k++) begin
            cmd_h = ($urandom % 2 == 0) ? 2'(($urandom % 4)) : 2'b00;
            cmd_v = ($urandom % 2 == 0) ? 2'(($urandom % 4)) : 2'b00;
            run(1 + int'($urandom % 40));
        end
        cmd_h = 2'b00; cmd_v = 2'b00;
        run(2 * LINE * FRAME);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule